// File: doc/BRIEF.md
# Timer Output Compare Unit

An 8-bit timer/counter with a single output compare channel. A CPU-side write interface sets the counter value, the compare value and a control word. The control word holds a waveform mode and a compare output action. The counter moves only on cycles where the timer-enable tick is high. On a tick where the counter equals the active compare value, a compare match occurs. The match sets a sticky flag and updates an internal output compare bit. The output action picks whether that bit is toggled, cleared or set.

The waveform mode is one of four:
- free-running count
- clear-on-match
- fast PWM
- phase-correct PWM

In the two PWM modes, CPU writes to the compare value are held in a shadow register. The shadow is moved into the active register when the count reaches its top. In the other two modes, the write takes effect at once. Writing the counter masks the match on the next tick. A force strobe drives the output bit like a match in non-PWM modes, but it does not touch the flag or the counter.

Phase-correct counting uses a two-state direction machine with states DIR_UP and DIR_DOWN:
- In DIR_UP, a tick at count 255 moves the machine to DIR_DOWN.
- In DIR_DOWN, a tick at count 0 moves it back to DIR_UP.
- In any other waveform mode, the machine is held in DIR_UP.

Top module: `tmr_ocu`

## Requirements
- R1: After reset the following values are 0:
  - the counter (`cnt_q`) and the active compare value (`cmp_q`)
  - the output bit (`oc_bit`), the flag (`cmp_flag`) and the pin source select (`pin_sel`)
  - the waveform mode, which resets to 00 (free-running count)
  - the output action, which resets to 00 (no action)
- R2: The counter changes only on a tick or a counter write. In waveform mode 00 (free-running) and mode 10 (fast PWM), each tick adds one, and 255 wraps to 0.
- R3: In waveform mode 01 (clear-on-match), a tick while the counter equals the active compare value loads 0; otherwise the tick adds one.
- R4: In waveform mode 11 (phase-correct PWM), the counter counts up to 255, then down to 0, then up again. The sequence passes 254, 255, 254, …, 1, 0, 1 and never holds a value for two ticks.
- R5: In modes 00 and 01, a compare write appears on `cmp_q` in the next cycle.
- R6: In modes 10 and 11, a compare write goes only to a shadow register. The shadow is copied to `cmp_q` on a tick where the counter is 255.
- R7: A match is a tick with counter equal to `cmp_q` and not blocked. A match sets `cmp_flag`. It also updates `oc_bit` by output action: 01 toggles, 10 clears, 11 sets, and 00 leaves it unchanged.
- R8: A counter write blocks any match on the next tick, however many cycles later that tick comes.
- R9: In modes 00 and 01, `force_strb` applies the output action to `oc_bit` without setting `cmp_flag` or changing the counter. In modes 10 and 11 it has no effect.
- R10: `flag_clr` high clears `cmp_flag`; a match in the same cycle wins and leaves it set.
- R11: `pin_sel` is 1 whenever the output action is nonzero. A control write changes it in the next cycle, with no wait for the count sequence.
- R12: `oc_bit` keeps its value across changes of waveform mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer-enable tick |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | 8 | Counter write value |
| cmp_wr | input | 1 | Compare value write strobe |
| cmp_wdata | input | 8 | Compare write value |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wave | input | 2 | Waveform mode: 00 free, 01 clear-on-match, 10 fast PWM, 11 phase-correct |
| ctl_oact | input | 2 | Output action: 00 none, 01 toggle, 10 clear, 11 set |
| force_strb | input | 1 | Force-compare strobe |
| flag_clr | input | 1 | Write-one-to-clear for the compare flag |
| cnt_q | output | 8 | Counter value |
| cmp_q | output | 8 | Active compare value |
| oc_bit | output | 1 | Output compare bit |
| pin_sel | output | 1 | 1: pin driven by `oc_bit`; 0: pin under port control |
| cmp_flag | output | 1 | Sticky compare match flag |

## Verification
- The counter and the active compare value are both visible at the ports, so most internal faults show within one tick:
  - a wrong direction state appears as a wrong `cnt_q` on the next tick of a phase-correct run;
  - an early or late shadow transfer appears on `cmp_q` at the first top tick.
- A lost or stuck match-blocking bit is hidden until the next tick that lands on the compare value. It then appears as a missing or extra flag in the following cycle.
- The bench tracks every output against a behavioural model on each clock. This exposes such faults at the first cycle in which they diverge.

// File: rtl/tmr_ocu_pkg.sv
package tmr_ocu_pkg;
    typedef enum logic [1:0] {
        WV_FREE     = 2'b00,
        WV_CLRMATCH = 2'b01,
        WV_FASTPWM  = 2'b10,
        WV_PHASEPWM = 2'b11
    } wave_e;

    typedef enum logic [1:0] {
        OA_NONE   = 2'b00,
        OA_TOGGLE = 2'b01,
        OA_CLEAR  = 2'b10,
        OA_SET    = 2'b11
    } oact_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;
endpackage

// File: rtl/tmr_ocu_counter.sv
module tmr_ocu_counter
    import tmr_ocu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  wave_e        wave,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt_wdata,
    input  logic [W-1:0] ocr,
    output logic [W-1:0] cnt_q,
    output logic         blk_q,
    output logic         at_top
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    dir_e         dir_q, dir_d;
    logic [W-1:0] cnt_d;

    assign at_top = (cnt_q == TOP);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= DIR_UP;
            cnt_q <= '0;
            blk_q <= 1'b0;
        end else begin
            dir_q <= dir_d;
            cnt_q <= cnt_d;
            if (cnt_wr)    blk_q <= 1'b1;
            else if (tick) blk_q <= 1'b0;
        end
    end

    // next state and count
    always_comb begin
        dir_d = dir_q;
        cnt_d = cnt_q;
        if (cnt_wr) begin
            cnt_d = cnt_wdata;
        end else if (tick) begin
            unique case (wave)
                WV_FREE, WV_FASTPWM: cnt_d = cnt_q + 1'b1;
                WV_CLRMATCH: cnt_d = (cnt_q == ocr) ? '0 : cnt_q + 1'b1;
                WV_PHASEPWM: begin
                    unique case (dir_q)
                        DIR_UP: begin
                            if (at_top) begin
                                cnt_d = cnt_q - 1'b1;
                                dir_d = DIR_DOWN;
                            end else begin
                                cnt_d = cnt_q + 1'b1;
                            end
                        end
                        DIR_DOWN: begin
                            if (cnt_q == '0) begin
                                cnt_d = cnt_q + 1'b1;
                                dir_d = DIR_UP;
                            end else begin
                                cnt_d = cnt_q - 1'b1;
                            end
                        end
                    endcase
                end
            endcase
        end
        if (wave != WV_PHASEPWM) dir_d = DIR_UP;
    end

    // R2
    hold_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> $stable(cnt_q));

    // R4
    down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && wave == WV_PHASEPWM && dir_q == DIR_DOWN && cnt_q != '0)
        |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/tmr_ocu_cmpbuf.sv
module tmr_ocu_cmpbuf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         is_pwm,
    input  logic         at_top,
    input  logic         cmp_wr,
    input  logic [W-1:0] cmp_wdata,
    output logic [W-1:0] ocr_q
);
    logic [W-1:0] shadow_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            ocr_q    <= '0;
        end else begin
            if (cmp_wr) begin
                shadow_q <= cmp_wdata;
                if (!is_pwm) ocr_q <= cmp_wdata;
            end
            if (is_pwm && tick && at_top) ocr_q <= shadow_q;
        end
    end

    // R6
    pwm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pwm && !(tick && at_top)) |=> $stable(ocr_q));
endmodule

// File: rtl/tmr_ocu_wavegen.sv
module tmr_ocu_wavegen
    import tmr_ocu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         blk,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] ocr,
    input  oact_e        oact,
    input  logic         is_pwm,
    input  logic         force_strb,
    input  logic         flag_clr,
    output logic         oc_q,
    output logic         flag_q
);
    logic hit, frc, oc_d;

    assign hit = tick && !blk && (cnt == ocr);
    assign frc = force_strb && !is_pwm;

    always_comb begin
        oc_d = oc_q;
        if (hit || frc) begin
            unique case (oact)
                OA_NONE:   oc_d = oc_q;
                OA_TOGGLE: oc_d = !oc_q;
                OA_CLEAR:  oc_d = 1'b0;
                OA_SET:    oc_d = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oc_q   <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            oc_q <= oc_d;
            if (hit)           flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
        end
    end

    // R8
    blocked_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && blk && !flag_q) |=> !flag_q);

    // R9
    pwm_force_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (force_strb && is_pwm && !tick) |=> $stable(oc_q));
endmodule

// File: rtl/tmr_ocu.sv
module tmr_ocu
    import tmr_ocu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt_wdata,
    input  logic         cmp_wr,
    input  logic [W-1:0] cmp_wdata,
    input  logic         ctl_wr,
    input  logic [1:0]   ctl_wave,
    input  logic [1:0]   ctl_oact,
    input  logic         force_strb,
    input  logic         flag_clr,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cmp_q,
    output logic         oc_bit,
    output logic         pin_sel,
    output logic         cmp_flag
);
    wave_e wave_q;
    oact_e oact_q;
    logic  is_pwm, blk, at_top;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wave_q <= WV_FREE;
            oact_q <= OA_NONE;
        end else if (ctl_wr) begin
            wave_q <= wave_e'(ctl_wave);
            oact_q <= oact_e'(ctl_oact);
        end
    end

    assign is_pwm  = (wave_q == WV_FASTPWM) || (wave_q == WV_PHASEPWM);
    assign pin_sel = (oact_q != OA_NONE);

    tmr_ocu_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wave(wave_q),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .ocr(cmp_q),
        .cnt_q(cnt_q), .blk_q(blk), .at_top(at_top)
    );

    tmr_ocu_cmpbuf #(.W(W)) u_buf (
        .clk(clk), .rst_n(rst_n), .tick(tick), .is_pwm(is_pwm),
        .at_top(at_top), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
        .ocr_q(cmp_q)
    );

    tmr_ocu_wavegen #(.W(W)) u_wav (
        .clk(clk), .rst_n(rst_n), .tick(tick), .blk(blk),
        .cnt(cnt_q), .ocr(cmp_q), .oact(oact_q), .is_pwm(is_pwm),
        .force_strb(force_strb), .flag_clr(flag_clr),
        .oc_q(oc_bit), .flag_q(cmp_flag)
    );

    // R12
    mode_keep_oc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !tick && !force_strb) |=> $stable(oc_bit));
endmodule

// File: tb/tmr_ocu_tb_top.sv
`timescale 1ns/1ps
module tmr_ocu_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 0, cnt_wr = 0, cmp_wr = 0, ctl_wr = 0, force_strb = 0, flag_clr = 0;
    logic [7:0] cnt_wdata = 0, cmp_wdata = 0;
    logic [1:0] ctl_wave = 0, ctl_oact = 0;
    logic [7:0] cnt_q, cmp_q;
    logic       oc_bit, pin_sel, cmp_flag;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit run_cmp = 0;

    always #4 clk = ~clk;

    tmr_ocu dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .ctl_wr(ctl_wr), .ctl_wave(ctl_wave),
        .ctl_oact(ctl_oact), .force_strb(force_strb), .flag_clr(flag_clr),
        .cnt_q(cnt_q), .cmp_q(cmp_q), .oc_bit(oc_bit), .pin_sel(pin_sel), .cmp_flag(cmp_flag)
    );

    // behavioural reference model
    int m_cnt, m_ocr, m_shd, m_oc, m_flag, m_blk, m_dir, m_wave, m_oact;
    always @(posedge clk) begin
        int n_cnt, n_ocr, n_shd, n_oc, n_flag, n_blk, n_dir;
        bit hit, frc;
        if (!rst_n) begin
            m_cnt = 0; m_ocr = 0; m_shd = 0; m_oc = 0; m_flag = 0;
            m_blk = 0; m_dir = 0; m_wave = 0; m_oact = 0;
        end else begin
            hit = tick && (m_blk == 0) && (m_cnt == m_ocr);
            frc = force_strb && (m_wave < 2);
            n_oc = m_oc;
            if (hit || frc) begin
                if (m_oact == 1) n_oc = 1 - m_oc;
                else if (m_oact == 2) n_oc = 0;
                else if (m_oact == 3) n_oc = 1;
            end
            n_flag = hit ? 1 : (flag_clr ? 0 : m_flag);
            n_cnt = m_cnt; n_dir = m_dir;
            if (cnt_wr) n_cnt = cnt_wdata;
            else if (tick) begin
                if (m_wave == 0 || m_wave == 2) n_cnt = (m_cnt + 1) % 256;
                else if (m_wave == 1) n_cnt = (m_cnt == m_ocr) ? 0 : (m_cnt + 1) % 256;
                else if (m_dir == 0) begin
                    if (m_cnt == 255) begin n_cnt = 254; n_dir = 1; end
                    else n_cnt = m_cnt + 1;
                end else begin
                    if (m_cnt == 0) begin n_cnt = 1; n_dir = 0; end
                    else n_cnt = m_cnt - 1;
                end
            end
            if (m_wave != 3) n_dir = 0;
            n_blk = cnt_wr ? 1 : (tick ? 0 : m_blk);
            n_shd = m_shd; n_ocr = m_ocr;
            if (cmp_wr) begin
                n_shd = cmp_wdata;
                if (m_wave < 2) n_ocr = cmp_wdata;
            end
            if (m_wave >= 2 && tick && m_cnt == 255) n_ocr = m_shd;
            m_cnt = n_cnt; m_ocr = n_ocr; m_shd = n_shd; m_oc = n_oc;
            m_flag = n_flag; m_blk = n_blk; m_dir = n_dir;
            if (ctl_wr) begin m_wave = ctl_wave; m_oact = ctl_oact; end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n && run_cmp) begin
            chk("R2 R3 R4 counter", cnt_q, m_cnt);
            chk("R5 R6 active compare", cmp_q, m_ocr);
            chk("R7 R9 R12 output bit", oc_bit, m_oc);
            chk("R7 R8 R10 flag", cmp_flag, m_flag);
            chk("R11 pin select", pin_sel, (m_oact != 0) ? 1 : 0);
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clr_in;
        tick = 0; cnt_wr = 0; cmp_wr = 0; ctl_wr = 0; force_strb = 0; flag_clr = 0;
    endtask

    task automatic set_ctl(input logic [1:0] w, input logic [1:0] a);
        ctl_wave = w; ctl_oact = a; ctl_wr = 1; @(negedge clk); clr_in();
    endtask

    task automatic set_cmp(input logic [7:0] v);
        cmp_wdata = v; cmp_wr = 1; @(negedge clk); clr_in();
    endtask

    task automatic set_cnt(input logic [7:0] v);
        cnt_wdata = v; cnt_wr = 1; @(negedge clk); clr_in();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin tick = 1; @(negedge clk); end
        tick = 0;
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1;
        @(negedge clk);
        // R1 reset values
        chk("R1 cnt", cnt_q, 0); chk("R1 cmp", cmp_q, 0); chk("R1 oc", oc_bit, 0);
        chk("R1 flag", cmp_flag, 0); chk("R1 pin", pin_sel, 0);
        run_cmp = 1;
        // R2 no tick, counter holds
        idle(5);
        chk("R2 hold", cnt_q, 0);
        // R5 R7 free mode toggle
        set_ctl(2'b00, 2'b01);
        set_cmp(8'd5);
        chk("R5 immediate", cmp_q, 5);
        ticks(300);
        flag_clr = 1; @(negedge clk); clr_in();
        chk("R10 cleared", cmp_flag, 0);
        // R8 counter write blocks next tick even when stopped
        set_cnt(8'd5);
        idle(4);
        ticks(1);
        chk("R8 blocked", cmp_flag, 0);
        // R9 force in free mode, no flag, no count change
        set_ctl(2'b00, 2'b11);
        force_strb = 1; @(negedge clk); clr_in();
        chk("R9 forced", oc_bit, 1);
        chk("R9 no flag", cmp_flag, 0);
        chk("R9 count kept", cnt_q, 6);
        // R3 clear-on-match
        set_ctl(2'b01, 2'b01);
        set_cmp(8'd10);
        set_cnt(8'd0);
        ticks(40);
        // R6 fast PWM buffering, R12 oc kept across mode change
        set_ctl(2'b10, 2'b10);
        set_cmp(8'd200);
        chk("R6 buffered", cmp_q, 10);
        ticks(600);
        // R4 phase-correct, force ignored
        set_ctl(2'b11, 2'b01);
        set_cmp(8'd100);
        ticks(700);
        force_strb = 1; @(negedge clk); clr_in();
        // R11 action change immediate
        set_ctl(2'b11, 2'b00);
        chk("R11 pin off", pin_sel, 0);
        // mixed random traffic
        for (int i = 0; i < 4000; i++) begin
            tick = ($urandom % 3) != 0;
            cnt_wr = ($urandom % 61) == 0; cnt_wdata = 8'($urandom);
            cmp_wr = ($urandom % 47) == 0; cmp_wdata = 8'($urandom);
            ctl_wr = ($urandom % 331) == 0; ctl_wave = 2'($urandom); ctl_oact = 2'($urandom);
            force_strb = ($urandom % 29) == 0; flag_clr = ($urandom % 13) == 0;
            @(negedge clk);
        end
        clr_in();
        idle(2);
        finish_run();
    end
endmodule